// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is a Clause 22 management master for external Ethernet PHYs. Software programs it through two 32-bit registers on a simple synchronous register bus. The command word at offset 0x00 holds the operation, PHY address, register address and write data, together with a start/busy bit. The configuration word at offset 0x04 holds the MDC divider and a preamble-suppress bit. When a command is launched, the block generates MDC from the reference clock. It shifts the management frame out on a split MDIO pad (data out, output enable, data in). For a read it releases the line and captures sixteen data bits.

The busy bit drops when the frame ends. After a read, the captured data replaces the data field of the command word. A read-fail flag reports a PHY that did not pull the second turnaround bit low. The flag stays set until the next frame is launched. The MDC divider resets to a value derived from the reference frequency, so that MDC never exceeds 2.5 MHz.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the command word reads 0 (busy bit 29 and fail bit 28 clear), the configuration word reads 0x311 (Clause 22 bit 0 set, divider field bits 9:4 = 49, preamble-suppress bit 12 clear), MDC is low and the MDIO output enable is low.
- R2: A write to offset 0x00 while idle stores opcode bits 27:26 (2'b10 read, 2'b01 write), PHY address bits 25:21, register address bits 20:16 and data bits 15:0, which read back unchanged. If bit 29 of the written word is 1, a frame starts and bit 29 reads 1 from the next cycle until the frame ends.
- R3: MDC stays low while idle. During a frame its period is 2×(div+1) reference clocks, where div is configuration bits 9:4.
- R4: With the preamble enabled, a frame is 64 MDC bits sent MSB first: 32 ones, start 01, the opcode, the PHY address, the register address, turnaround, then 16 data bits. A write frame drives the turnaround as 10 and sends the command data.
- R5: With configuration bit 12 set, the 32 preamble bits are omitted and the frame is 32 MDC bits long, starting with the start pattern.
- R6: In a read frame the master drives the first 46 bits and holds the output enable low from the first turnaround bit to the end. It samples MDIO on the 16 data-bit rising edges, MSB first. Once busy clears, the captured data is returned in command bits 15:0.
- R7: Bit 28 is set at the end of a read whose second turnaround bit was sampled high. It is cleared when the next frame is launched. A write frame never sets it.
- R8: A write to offset 0x00 while busy has no effect: the frame in flight and the stored command fields are unchanged, and no new frame follows.
- R9: The master changes MDIO data and output enable only on MDC falling edges. During a write frame it drives every bit.
- R10: The frame ends on the MDC falling edge after the last bit. Busy clears, MDC remains low and the output enable goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Register write strobe (with bus_sel) |
| bus_addr | input | BUS_AW | Byte offset of the register |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO data toward the pad |
| mdio_oe | output | 1 | MDIO pad output enable |
| mdio_i | input | 1 | MDIO data from the pad |

## Verification
A corrupted bit position or shift register shows within one frame as a wrong bit at a specific MDC rising edge. A position counter stuck short of the last bit shows as a busy flag that never clears, or as a frame of the wrong length. A wrong release point shows as the output enable being high or low at the turnaround edges. A broken capture path or a broken fail latch appears in the command word as soon as busy drops. A divider fault shows on the first two MDC rising edges as the wrong spacing.

// File: rtl/mdioc_pkg.sv
package mdioc_pkg;

    // register byte offsets
    localparam int CMD_OFS = 0;
    localparam int CFG_OFS = 4;

    // command word layout
    localparam int CMD_BUSY_BIT = 29;
    localparam int CMD_FAIL_BIT = 28;
    localparam int CMD_OP_LSB   = 26;
    localparam int CMD_PHY_LSB  = 21;
    localparam int CMD_REG_LSB  = 16;

    // configuration word layout
    localparam int CFG_C22_BIT   = 0;
    localparam int CFG_DIV_LSB   = 4;
    localparam int CFG_NOPRE_BIT = 12;

    // field widths
    localparam int OP_W     = 2;
    localparam int PHY_AW   = 5;
    localparam int REG_AW   = 5;
    localparam int DATA_W   = 16;
    localparam int CLKDIV_W = 6;

    // frame geometry
    localparam int PRE_LEN = 32;
    localparam int TA_OFS  = 2 + OP_W + PHY_AW + REG_AW;
    localparam int HDR_LEN = TA_OFS + 2 + DATA_W;

    localparam logic [1:0] START_PAT = 2'b01;
    localparam logic [1:0] TA_PAT    = 2'b10;
    localparam logic [OP_W-1:0] OP_READ  = 2'b10;
    localparam logic [OP_W-1:0] OP_WRITE = 2'b01;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [PHY_AW-1:0] phy;
        logic [REG_AW-1:0] regad;
        logic [DATA_W-1:0] data;
    } mdio_cmd_t;

endpackage

// File: rtl/mdioc_clkdiv.sv
module mdioc_clkdiv #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_state_t;

    div_state_t s_q, s_d;

    always_comb begin
        s_d  = s_q;
        rise = 1'b0;
        fall = 1'b0;
        if (!run) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else if (s_q.cnt >= div) begin
            s_d.cnt = '0;
            s_d.mdc = !s_q.mdc;
            rise    = !s_q.mdc;
            fall    = s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mdc = s_q.mdc;

    // idle forces the clock low on the next edge
    assert_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

    // a rising strobe always leads to a high clock
    assert_rise_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> mdc);

endmodule

// File: rtl/mdioc_seq.sv
module mdioc_seq
    import mdioc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  mdio_cmd_t         cmd,
    input  logic              no_pre,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_fail
);

    localparam int FRAME_LEN = PRE_LEN + HDR_LEN;
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam logic [POS_W-1:0] POS_HDR  = POS_W'(PRE_LEN);
    localparam logic [POS_W-1:0] POS_TA   = POS_W'(PRE_LEN + TA_OFS);
    localparam logic [POS_W-1:0] POS_TA2  = POS_W'(PRE_LEN + TA_OFS + 1);
    localparam logic [POS_W-1:0] POS_DATA = POS_W'(PRE_LEN + TA_OFS + 2);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic               busy;
        logic               rd;
        logic               fail;
        logic [POS_W-1:0]   pos;
        logic [HDR_LEN-1:0] hdr;
        logic [DATA_W-1:0]  shift;
    } seq_state_t;

    seq_state_t s_q, s_d;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (!s_q.busy) begin
            if (launch) begin
                s_d.busy  = 1'b1;
                s_d.rd    = (cmd.op == OP_READ);
                s_d.fail  = 1'b0;
                s_d.pos   = no_pre ? POS_HDR : '0;
                s_d.hdr   = {START_PAT, cmd.op, cmd.phy, cmd.regad, TA_PAT, cmd.data};
                s_d.shift = '0;
            end
        end else begin
            if (rise && s_q.rd) begin
                if (s_q.pos == POS_TA2 && mdio_i) begin
                    s_d.fail = 1'b1;
                end
                if (s_q.pos >= POS_DATA) begin
                    s_d.shift = {s_q.shift[DATA_W-2:0], mdio_i};
                end
            end
            if (fall) begin
                if (s_q.pos == POS_LAST) begin
                    s_d.busy = 1'b0;
                    done     = 1'b1;
                end else begin
                    s_d.pos = s_q.pos + 1'b1;
                    if (s_q.pos >= POS_HDR) begin
                        s_d.hdr = s_q.hdr << 1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = s_q.busy;
    assign mdio_oe = s_q.busy && !(s_q.rd && s_q.pos >= POS_TA);
    assign mdio_o  = !s_q.busy || (s_q.pos < POS_HDR) || s_q.hdr[HDR_LEN-1];
    assign rd_data = s_q.shift;
    assign rd_fail = s_q.fail;

    // pad outputs move only on a falling MDC strobe
    assert_drive_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !fall) |=> ($stable(mdio_o) && $stable(mdio_oe)));

    // once a read has released the line it stays released until the end
    assert_release_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.rd && !mdio_oe) |=> (!mdio_oe || !s_q.busy));

    // only a read can raise the fail flag
    assert_fail_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_fail) |-> s_q.rd);

    // a frame ends only on a falling strobe
    assert_end_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(fall));

endmodule

// File: rtl/mdioc_regs.sv
module mdioc_regs
    import mdioc_pkg::*;
#(
    parameter int                    BUS_AW  = 4,
    parameter logic [CLKDIV_W-1:0]   RST_DIV = 6'd49
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                busy,
    input  logic                done,
    input  logic [DATA_W-1:0]   seq_rd_data,
    input  logic                seq_fail,
    output mdio_cmd_t           launch_cmd,
    output logic                launch,
    output logic [CLKDIV_W-1:0] div,
    output logic                no_pre
);

    localparam logic [BUS_AW-1:0] A_CMD = BUS_AW'(CMD_OFS);
    localparam logic [BUS_AW-1:0] A_CFG = BUS_AW'(CFG_OFS);

    typedef struct packed {
        mdio_cmd_t           cmd;
        logic                c22;
        logic [CLKDIV_W-1:0] div;
        logic                nopre;
    } reg_state_t;

    reg_state_t s_q, s_d;
    logic       wr_cmd, wr_cfg;
    logic       unused_wdata;

    assign unused_wdata = ^bus_wdata[31:30];

    assign wr_cmd = bus_sel && bus_wr && (bus_addr == A_CMD);
    assign wr_cfg = bus_sel && bus_wr && (bus_addr == A_CFG);

    assign launch_cmd.op    = bus_wdata[CMD_OP_LSB +: OP_W];
    assign launch_cmd.phy   = bus_wdata[CMD_PHY_LSB +: PHY_AW];
    assign launch_cmd.regad = bus_wdata[CMD_REG_LSB +: REG_AW];
    assign launch_cmd.data  = bus_wdata[DATA_W-1:0];

    always_comb begin
        s_d    = s_q;
        launch = 1'b0;
        if (done && s_q.cmd.op == OP_READ) begin
            s_d.cmd.data = seq_rd_data;
        end
        if (wr_cmd && !busy) begin
            s_d.cmd = launch_cmd;
            launch  = bus_wdata[CMD_BUSY_BIT];
        end
        if (wr_cfg) begin
            s_d.c22   = bus_wdata[CFG_C22_BIT];
            s_d.div   = bus_wdata[CFG_DIV_LSB +: CLKDIV_W];
            s_d.nopre = bus_wdata[CFG_NOPRE_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cmd   <= '0;
            s_q.c22   <= 1'b1;
            s_q.div   <= RST_DIV;
            s_q.nopre <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CMD) begin
            bus_rdata[CMD_BUSY_BIT]              = busy;
            bus_rdata[CMD_FAIL_BIT]              = seq_fail;
            bus_rdata[CMD_OP_LSB +: OP_W]        = s_q.cmd.op;
            bus_rdata[CMD_PHY_LSB +: PHY_AW]     = s_q.cmd.phy;
            bus_rdata[CMD_REG_LSB +: REG_AW]     = s_q.cmd.regad;
            bus_rdata[DATA_W-1:0]                = s_q.cmd.data;
        end else if (bus_addr == A_CFG) begin
            bus_rdata[CFG_C22_BIT]               = s_q.c22;
            bus_rdata[CFG_DIV_LSB +: CLKDIV_W]   = s_q.div;
            bus_rdata[CFG_NOPRE_BIT]             = s_q.nopre;
        end
    end

    assign div    = s_q.div;
    assign no_pre = s_q.nopre;

    // launches are accepted only while idle
    assert_launch_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy);

    // addressing fields are frozen while a frame is in flight
    assert_fields_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({s_q.cmd.op, s_q.cmd.phy, s_q.cmd.regad}));

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdioc_pkg::*;
#(
    parameter int BUS_AW     = 4,
    parameter int REF_HZ     = 250_000_000,
    parameter int MDC_MAX_HZ = 2_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    // smallest divider that keeps MDC at or below the ceiling
    localparam int DIV_RAW = (REF_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ) - 1;
    localparam int DIV_MAX = (1 << CLKDIV_W) - 1;
    localparam int DIV_SAT = (DIV_RAW > DIV_MAX) ? DIV_MAX : ((DIV_RAW < 0) ? 0 : DIV_RAW);
    localparam logic [CLKDIV_W-1:0] RST_DIV = CLKDIV_W'(DIV_SAT);

    mdio_cmd_t           launch_cmd;
    logic                launch;
    logic [CLKDIV_W-1:0] div;
    logic                no_pre;
    logic                busy;
    logic                done;
    logic [DATA_W-1:0]   rd_data;
    logic                rd_fail;
    logic                rise, fall;

    mdioc_regs #(
        .BUS_AW  (BUS_AW),
        .RST_DIV (RST_DIV)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .busy        (busy),
        .done        (done),
        .seq_rd_data (rd_data),
        .seq_fail    (rd_fail),
        .launch_cmd  (launch_cmd),
        .launch      (launch),
        .div         (div),
        .no_pre      (no_pre)
    );

    mdioc_clkdiv #(
        .DIV_W (CLKDIV_W)
    ) u_clkdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (div),
        .mdc   (mdc),
        .rise  (rise),
        .fall  (fall)
    );

    mdioc_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .cmd     (launch_cmd),
        .no_pre  (no_pre),
        .rise    (rise),
        .fall    (fall),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done    (done),
        .rd_data (rd_data),
        .rd_fail (rd_fail)
    );

    // MDC is high only inside a frame
    assert_mdc_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> busy);

    // the pad is never driven outside a frame
    assert_oe_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);

endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mdio_mgmt_master u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0;
    endtask

    function automatic logic exp_bit(input int p, input logic [1:0] op,
                                     input logic [4:0] phy, input logic [4:0] rg,
                                     input logic [15:0] dat);
        logic [31:0] h;
        h = {2'b01, op, phy, rg, 2'b10, dat};
        if (p < 32) return 1'b1;
        return h[63 - p];
    endfunction

    task automatic run_frame(input logic [1:0] op, input logic [4:0] phy,
                             input logic [4:0] rg, input logic [15:0] dat,
                             input logic sup, input logic [5:0] dv,
                             input logic set_cfg, input logic [15:0] rdv,
                             input logic ta_bad, input logic intrude);
        logic o_bits[64];
        logic oe_bits[64];
        logic prev;
        logic intr_on;
        logic [31:0] rd;
        int nb, off, t1, t2, guard, bitbad, oebad;
        off = sup ? 32 : 0;
        if (set_cfg) bus_write(4'h4, {19'd0, sup, 2'b00, dv, 3'b000, 1'b1});
        bus_write(4'h0, {2'b00, 1'b1, 1'b0, op, phy, rg, dat});
        chk("R2", "busy after launch", 32'(bus_rdata[29]), 32'd1);
        chk("R7", "fail cleared at launch", 32'(bus_rdata[28]), 32'd0);
        nb = 0; t1 = 0; t2 = 0; guard = 0; prev = mdc; intr_on = 1'b0;
        for (int k = 0; k < 64; k++) begin o_bits[k] = 1'b0; oe_bits[k] = 1'b0; end
        while (1) begin
            if (intr_on) begin
                bus_sel = 1'b0; bus_wr = 1'b0; intr_on = 1'b0;
            end
            if (mdc && !prev) begin
                if (nb < 64) begin o_bits[nb] = mdio_o; oe_bits[nb] = mdio_oe; end
                if (nb == 0) t1 = cyc;
                if (nb == 1) t2 = cyc;
                nb++;
                if (intrude && nb == 10) begin
                    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h0;
                    bus_wdata = {2'b00, 1'b1, 1'b0, ~op, ~phy, ~rg, ~dat};
                    intr_on = 1'b1;
                end
            end
            if (!mdc && prev) begin
                int p;
                p = nb + off;
                if (p == 47) mdio_i = ta_bad;
                else if (p >= 48 && p <= 63) mdio_i = rdv[63 - p];
                else mdio_i = 1'b1;
            end
            prev = mdc;
            if (!bus_rdata[29]) break;
            guard++;
            if (guard > 30000) begin
                chk("R10", "frame never ended", 32'd1, 32'd0);
                break;
            end
            @(negedge clk);
        end
        mdio_i = 1'b1;
        chk(sup ? "R5" : "R4", "bit count", 32'(nb), 32'(64 - off));
        bitbad = 0; oebad = 0;
        for (int i = 0; i < nb && i < 64; i++) begin
            int p;
            p = i + off;
            if (op == 2'b10 && p >= 46) begin
                if (oe_bits[i] !== 1'b0) oebad++;
            end else begin
                if (oe_bits[i] !== 1'b1) oebad++;
                if (o_bits[i] !== exp_bit(p, op, phy, rg, dat)) bitbad++;
            end
        end
        chk(sup ? "R5" : "R4", "frame bit mismatches", 32'(bitbad), 32'd0);
        chk(op == 2'b10 ? "R6" : "R9", "drive-enable mismatches", 32'(oebad), 32'd0);
        chk("R3", "MDC period", 32'(t2 - t1), 32'(2 * (int'(dv) + 1)));
        chk("R10", "MDC low at end", 32'(mdc), 32'd0);
        chk("R10", "output enable low at end", 32'(mdio_oe), 32'd0);
        rd = bus_rdata;
        chk(intrude ? "R8" : "R2", "stored fields", 32'(rd[27:16]), 32'({op, phy, rg}));
        chk(op == 2'b10 ? "R6" : "R2", "data field", 32'(rd[15:0]),
            32'(op == 2'b10 ? rdv : dat));
        chk("R7", "fail flag", 32'(rd[28]), 32'(op == 2'b10 && ta_bad));
        repeat (6) @(negedge clk);
        chk(intrude ? "R8" : "R10", "stays idle", 32'(bus_rdata[29]), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0;
        bus_wdata = '0; mdio_i = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "command word", bus_rdata, 32'h0);
        chk("R1", "MDC", 32'(mdc), 32'd0);
        chk("R1", "output enable", 32'(mdio_oe), 32'd0);
        bus_addr = 4'h4; #1;
        chk("R1", "config word", bus_rdata, 32'h0000_0311);
        bus_addr = 4'h0;

        // R2 store without start, R3 idle clock stays low
        bus_write(4'h0, 32'h0ABC_1234);
        chk("R2", "readback without start", bus_rdata, 32'h0ABC_1234);
        begin
            int hi = 0;
            repeat (20) begin @(negedge clk); if (mdc) hi++; end
            chk("R3", "idle MDC high samples", 32'(hi), 32'd0);
        end

        // default divider write frame
        run_frame(2'b01, 5'h03, 5'h01, 16'hA5C3, 1'b0, 6'd49, 1'b0, 16'h0, 1'b0, 1'b0);
        // directed: suppressed-preamble read, fast divider
        run_frame(2'b10, 5'h1F, 5'h02, 16'h0000, 1'b1, 6'd0, 1'b1, 16'h8001, 1'b0, 1'b0);
        // directed: bad turnaround, then a write that must clear the flag
        run_frame(2'b10, 5'h00, 5'h1F, 16'h0000, 1'b0, 6'd1, 1'b1, 16'h5A5A, 1'b1, 1'b0);
        run_frame(2'b01, 5'h11, 5'h0A, 16'hFFFF, 1'b0, 6'd1, 1'b1, 16'h0, 1'b0, 1'b0);
        // directed: write to command while busy
        run_frame(2'b01, 5'h05, 5'h06, 16'h1357, 1'b0, 6'd2, 1'b1, 16'h0, 1'b0, 1'b1);
        run_frame(2'b10, 5'h0C, 5'h13, 16'h0000, 1'b1, 6'd2, 1'b1, 16'hC0DE, 1'b0, 1'b1);

        // constrained random frames
        for (int n = 0; n < 12; n++) begin
            logic [1:0]  op;
            logic [31:0] r;
            r  = $urandom;
            op = r[0] ? 2'b10 : 2'b01;
            run_frame(op, 5'($urandom), 5'($urandom), 16'($urandom), r[1],
                      6'($urandom_range(0, 4)), 1'b1, 16'($urandom),
                      (r[4:2] == 3'd0), 1'b0);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule